// File: doc/BRIEF.md
# Oscillator Trim and Temperature-Sense Controller

This block holds the configuration state of a temperature-compensated clock oscillator and runs its temperature measurement. A host reaches it through a simple synchronous register port: an address, a write strobe with write data, and a read-data bus that is combinational from the address. It keeps a 6-bit initial trim code and turns it into a signed trim value. It also holds a read-only curvature coefficient and a 5-bit factory field, both loaded from presets at reset, and a control byte whose top three bits are the only ones the host can write.

When the host sets the sense-enable bit, the block runs two conversions in sequence on an abstract ADC. For each conversion it sends a one-cycle start pulse, then waits for a done pulse that carries a 10-bit sample. When both samples are in, it averages them and stores the average in a read-only result register. A busy flag can be read while the cycle runs. Clearing the enable part way through aborts the cycle. The trim sent to the oscillator is the decoded initial trim while sensing is off, and the externally adjusted trim while sensing is on.

Top module: `osc_trim_ctrl`

## Requirements
- R1: The trim-code register at address 0x08 holds 6 bits in bits 5:0. It resets to 6'b100000, can be read and written, and reads bits 7:6 as zero.
- R2: The trim code decodes to the signed value 32 minus the code. A code with MSB 0 is positive (011111 gives +1, 010011 gives +13, 000000 gives +32), 100000 gives 0, and 111111 gives -31. The value is presented on `osc_trim` as 7-bit two's complement.
- R3: Address 0x0C reads the factory coefficient preset (default 70, 8'b01000110). Host writes to it have no effect.
- R4: At address 0x0D, bit 7 is sense enable, bit 6 is battery-sense enable and bit 5 is battery-sense rate. A write changes only bits 7:5. Bits 4:0 always read the factory preset (default 5'h13).
- R5: After reset, bits 7:5 of 0x0D read 0, the busy flag reads 0, the result reads 0, and `adc_start` is low.
- R6: A write that takes sense enable from 0 to 1 starts a cycle. The cycle issues a one-cycle `adc_start`, waits for `adc_done`, issues a second one-cycle `adc_start`, and waits for a second `adc_done`. That makes exactly two starts per cycle.
- R7: When the cycle completes, the result register is loaded with (sample1 + sample2) >> 1, truncated. Result bits 7:0 read at 0x0E and bits 9:8 read at bits 1:0 of 0x0F. The register changes at no other time.
- R8: Bit 7 of 0x0F is the busy flag. It is 1 from the clock edge that accepts the enabling write until the result is stored, and 0 at all other times.
- R9: Clearing sense enable during a cycle aborts it. Busy drops, the result keeps its previous value, and no further `adc_start` is issued.
- R10: `osc_trim` equals `adj_trim` while sense enable is 1, and equals the decoded initial trim while it is 0.
- R11: Writing 1 to sense enable while it is already 1 does not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Read data for `addr` |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion complete, qualifies `adc_sample` |
| adc_sample | input | 10 | Conversion result |
| adj_trim | input | 7 | Signed trim from the compensation logic |
| osc_trim | output | 7 | Signed trim applied to the oscillator |

## Verification
The bench walks the trim decode across its edges: code 000000 (+32), 011111 (+1), 100000 (0) and 111111 (-31). A design that decoded the MSB as a plain sign bit would give -0 or +31 at these codes. It writes all ones to the coefficient and control bytes to catch a missing write mask, which would overwrite the factory bits. It runs averaging cycles with odd sums, with maximum-scale samples, and with a zero-and-one pair. A design that rounded instead of truncating, or that lost the carry of the sum, would store a wrong result. It aborts a cycle while the first conversion is pending and rewrites the enable while it is already set. A design that still stored a result, kept busy high, or restarted the ADC would show an extra start pulse or a changed result.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CONV1 = 2'd1,
    SQ_CONV2 = 2'd2,
    SQ_AVG   = 2'd3
  } seq_state_t;

  localparam logic [7:0] A_TRIM   = 8'h08;
  localparam logic [7:0] A_COEF   = 8'h0C;
  localparam logic [7:0] A_CTRL   = 8'h0D;
  localparam logic [7:0] A_RES_LO = 8'h0E;
  localparam logic [7:0] A_RES_HI = 8'h0F;
endpackage

// File: rtl/trim_decode.sv
module trim_decode #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W:0]   trim_o
);
  localparam int OUT_W = CODE_W + 1;
  localparam logic [OUT_W-1:0] MIDPOINT = OUT_W'(1 << (CODE_W - 1));

  // midpoint minus code covers both halves of the offset mapping
  always_comb begin
    trim_o = MIDPOINT - {1'b0, code_i};
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import osc_trim_pkg::*;
#(
  parameter int          CODE_W     = 6,
  parameter logic [7:0]  COEF_PRESET = 8'd70,
  parameter logic [4:0]  FAC_PRESET  = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [CODE_W-1:0] trim_code,
  output logic [2:0]        ctrl_bits,
  output logic [7:0]        coef,
  output logic [4:0]        fac_bits,
  output logic              go
);
  localparam logic [CODE_W-1:0] TRIM_RST = CODE_W'(1 << (CODE_W - 1));

  logic [CODE_W-1:0] trim_q, trim_n;
  logic [2:0]        ctrl_q, ctrl_n;
  logic [7:0]        coef_q;
  logic [4:0]        fac_q;
  logic              trim_we, ctrl_we;

  always_comb begin
    trim_we = wr_en && (addr == A_TRIM);
    ctrl_we = wr_en && (addr == A_CTRL);
    trim_n  = trim_we ? wdata[CODE_W-1:0] : trim_q;
    ctrl_n  = ctrl_we ? wdata[7:5] : ctrl_q;
    go      = ctrl_we && wdata[7] && !ctrl_q[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= TRIM_RST;
      ctrl_q <= 3'b000;
    end else begin
      trim_q <= trim_n;
      ctrl_q <= ctrl_n;
    end
  end

  // factory values: loaded by reset only, no write path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= COEF_PRESET;
      fac_q  <= FAC_PRESET;
    end
  end

  assign trim_code = trim_q;
  assign ctrl_bits = ctrl_q;
  assign coef      = coef_q;
  assign fac_bits  = fac_q;
endmodule

// File: rtl/sense_seq.sv
module sense_seq
  import osc_trim_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                en,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_sample,
  output logic                adc_start,
  output logic                busy,
  output logic [SAMPLE_W-1:0] result
);
  seq_state_t          state_q, state_n;
  logic [SAMPLE_W-1:0] s1_q, s1_n, s2_q, s2_n, res_q, res_n;
  logic                start_q, start_n;
  logic [SAMPLE_W:0]   sum;

  always_comb begin
    state_n = state_q;
    s1_n    = s1_q;
    s2_n    = s2_q;
    res_n   = res_q;
    sum     = {1'b0, s1_q} + {1'b0, s2_q};
    case (state_q)
      SQ_IDLE:  if (go) state_n = SQ_CONV1;
      SQ_CONV1: if (!en) state_n = SQ_IDLE;
                else if (adc_done) begin
                  s1_n    = adc_sample;
                  state_n = SQ_CONV2;
                end
      SQ_CONV2: if (!en) state_n = SQ_IDLE;
                else if (adc_done) begin
                  s2_n    = adc_sample;
                  state_n = SQ_AVG;
                end
      SQ_AVG: begin
        if (en) res_n = sum[SAMPLE_W:1];
        state_n = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
    start_n = ((state_n == SQ_CONV1) && (state_q != SQ_CONV1)) ||
              ((state_n == SQ_CONV2) && (state_q != SQ_CONV2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      s1_q    <= '0;
      s2_q    <= '0;
      res_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_n;
      s1_q    <= s1_n;
      s2_q    <= s2_n;
      res_q   <= res_n;
      start_q <= start_n;
    end
  end

  assign adc_start = start_q;
  assign busy      = (state_q != SQ_IDLE);
  assign result    = res_q;

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> !busy);
  p_result_only_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(state_q == SQ_AVG));
  p_start_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int         CODE_W      = 6,
  parameter int         SAMPLE_W    = 10,
  parameter logic [7:0] COEF_PRESET = 8'd70,
  parameter logic [4:0] FAC_PRESET  = 5'h13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          addr,
  input  logic [7:0]          wdata,
  input  logic                wr_en,
  output logic [7:0]          rdata,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic [CODE_W:0]     adj_trim,
  output logic [CODE_W:0]     osc_trim
);
  localparam int HI_W = SAMPLE_W - 8;

  logic [CODE_W-1:0]   trim_code;
  logic [CODE_W:0]     init_trim;
  logic [2:0]          ctrl_bits;
  logic [7:0]          coef;
  logic [4:0]          fac_bits;
  logic                go, busy;
  logic [SAMPLE_W-1:0] result;

  cfg_regs #(.CODE_W(CODE_W), .COEF_PRESET(COEF_PRESET), .FAC_PRESET(FAC_PRESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .trim_code(trim_code), .ctrl_bits(ctrl_bits), .coef(coef),
    .fac_bits(fac_bits), .go(go)
  );

  trim_decode #(.CODE_W(CODE_W)) u_dec (
    .code_i(trim_code), .trim_o(init_trim)
  );

  sense_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .en(ctrl_bits[2]),
    .adc_done(adc_done), .adc_sample(adc_sample),
    .adc_start(adc_start), .busy(busy), .result(result)
  );

  always_comb begin
    osc_trim = ctrl_bits[2] ? adj_trim : init_trim;
    case (addr)
      A_TRIM:   rdata = 8'(trim_code);
      A_COEF:   rdata = coef;
      A_CTRL:   rdata = {ctrl_bits, fac_bits};
      A_RES_LO: rdata = result[7:0];
      A_RES_HI: rdata = {busy, {(7-HI_W){1'b0}}, result[SAMPLE_W-1:8]};
      default:  rdata = 8'h00;
    endcase
  end

  p_coef_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_COEF) |-> (rdata == COEF_PRESET));
  p_ctrl_factory_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rdata[4:0] == FAC_PRESET));
endmodule

// File: tb/sim_osc_trim_ctrl.sv
module sim_osc_trim_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr, wdata, rdata;
  logic       wr_en, adc_start, adc_done;
  logic [9:0] adc_sample;
  logic [6:0] adj_trim, osc_trim;

  int tests = 0, fails = 0, starts = 0, adc_dly = 2;
  bit adc_hold = 0;
  logic [9:0] samp_q[$];
  int exp_q[$];

  always #2 clk = ~clk;

  osc_trim_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .adc_start(adc_start), .adc_done(adc_done),
    .adc_sample(adc_sample), .adj_trim(adj_trim), .osc_trim(osc_trim)
  );

  always @(posedge clk) if (rst_n && adc_start) starts++;

  // ADC model: answers each start after adc_dly cycles with the next queued sample
  initial begin
    adc_done = 0; adc_sample = '0;
    forever begin
      @(posedge clk);
      if (adc_start && !adc_hold) begin
        repeat (adc_dly) @(negedge clk);
        adc_sample = (samp_q.size() > 0) ? samp_q.pop_front() : 10'd0;
        adc_done = 1;
        @(negedge clk);
        adc_done = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(8'h0F, v);
      if (!v[7]) break;
    end
  endtask

  // monitor: pops the expected average and compares it to the stored result
  task automatic monitor_result();
    logic [7:0] lo, hi;
    int e;
    e = exp_q.pop_front();
    rd(8'h0E, lo); rd(8'h0F, hi);
    chk("R7 averaged result", {hi[1:0], lo}, e);
  endtask

  // driver: queues samples and the expected average, then runs a cycle
  task automatic run_conv(int a, int b);
    logic [7:0] v;
    int s0;
    samp_q.push_back(10'(a)); samp_q.push_back(10'(b));
    exp_q.push_back((a + b) >> 1);
    s0 = starts;
    wr(8'h0D, 8'h80);
    rd(8'h0F, v);
    chk("R8 busy during cycle", v[7], 1);
    wait_idle();
    chk("R6 two starts per cycle", starts - s0, 2);
    monitor_result();
    wr(8'h0D, 8'h00);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int s0;
    rst_n = 0; addr = 0; wdata = 0; wr_en = 0; adj_trim = 7'sd0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk("R5 adc_start idle", adc_start, 0);
    rd(8'h0D, v); chk("R5 ctrl reset", v, 8'h13);
    rd(8'h0F, v); chk("R5 busy/result hi reset", v, 0);
    rd(8'h0E, v); chk("R5 result lo reset", v, 0);
    rd(8'h08, v); chk("R1 trim reset", v, 8'h20);
    chk("R2 trim at reset", $signed(osc_trim), 0);

    wr(8'h08, 8'hFF); rd(8'h08, v); chk("R1 trim width", v, 8'h3F);
    chk("R2 code 111111", $signed(osc_trim), -31);
    wr(8'h08, 8'h13); chk("R2 code 010011", $signed(osc_trim), 13);
    wr(8'h08, 8'h1F); chk("R2 code 011111", $signed(osc_trim), 1);
    wr(8'h08, 8'h00); chk("R2 code 000000", $signed(osc_trim), 32);
    wr(8'h08, 8'h21); chk("R2 code 100001", $signed(osc_trim), -1);

    wr(8'h0C, 8'hFF); rd(8'h0C, v); chk("R3 coefficient read-only", v, 70);

    wr(8'h0D, 8'h7F); rd(8'h0D, v); chk("R4 write mask", v, 8'h73);
    wr(8'h0D, 8'h00); rd(8'h0D, v); chk("R4 clear writable bits", v, 8'h13);

    run_conv(512, 300);
    adc_dly = 5;
    run_conv(1023, 1022);
    adc_dly = 1;
    run_conv(0, 1);
    run_conv(7, 8);

    // R10: adjusted trim while enabled
    adj_trim = 7'h75;
    samp_q.push_back(10'd100); samp_q.push_back(10'd201);
    exp_q.push_back(150);
    wr(8'h0D, 8'h80);
    chk("R10 adjusted trim selected", osc_trim, 7'h75);
    wait_idle();
    monitor_result();
    // R11: rewrite of enable while set
    s0 = starts;
    wr(8'h0D, 8'hE0);
    repeat (20) @(negedge clk);
    chk("R11 no restart", starts - s0, 0);
    rd(8'h0D, v); chk("R11 ctrl readback", v, 8'hF3);
    wr(8'h0D, 8'h00);
    chk("R10 initial trim selected", $signed(osc_trim), -1);

    // R9: abort while first conversion is pending
    adc_hold = 1;
    s0 = starts;
    wr(8'h0D, 8'h80);
    repeat (3) @(negedge clk);
    rd(8'h0F, v); chk("R9 busy before abort", v[7], 1);
    wr(8'h0D, 8'h00);
    rd(8'h0F, v); chk("R9 busy cleared by abort", v[7], 0);
    repeat (10) @(negedge clk);
    chk("R9 no further start", starts - s0, 1);
    rd(8'h0E, v); chk("R9 result kept", v, 150);
    adc_hold = 0;

    finish_up();
  end
endmodule